// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Request

This block sits between a serial receiver and the host register interface of a UART. Received bytes enter a 16-entry first-in first-out store. The host drains it one byte per read strobe. A single control byte decides three things: whether queuing is on, whether the receive store is emptied now, and at which fill level a data-available request is raised. The same control byte can also ask the neighbouring transmit queue to empty, which the block passes on as a one-cycle pulse.

With queuing off, the block keeps only one byte, like a plain holding register. In that mode the other control bits do nothing. The block reports whether data is waiting and whether a byte was lost to a full store. It also reports which queue mode is active, as a two-bit code. A character timeout request tells the host that a few bytes are sitting below the threshold and the line has gone quiet. Time is counted in bit-clock ticks supplied by the receiver.

Top module: `rxq_top`

## Requirements
- R1: After reset, level, data_ready, avail_req, timeout_req, overrun and tx_flush are 0, and fifo_mode is 2'b00 (queuing off).
- R2: A control write takes its bit 0 as the queue enable. From the next cycle, fifo_mode reads 2'b11 when the enable is 1 and 2'b00 when it is 0.
- R3: With queuing off, the store holds at most one byte and the threshold is 1. A control write that keeps bit 0 at 0 neither clears the store nor pulses tx_flush, whatever bits 7:1 hold.
- R4: With queuing on, a control write with bit 1 set empties the receive store: level is 0 on the next cycle. A write with bit 2 set gives tx_flush high for exactly one cycle. Neither bit has any effect on later cycles.
- R5: With queuing on, control bits 7:6 choose the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. avail_req is 1 while level is at or above the threshold.
- R6: data_ready is 1 exactly while level is nonzero.
- R7: Bytes come out of rd_data in arrival order. rd_data shows the popped byte in the cycle after rd_en.
- R8: A byte that arrives when the store is at capacity (16, or 1 with queuing off) is dropped, and overrun is set. overrun stays set until an lsr_rd strobe clears it.
- R9: rd_en on an empty store leaves level at 0 and rd_data unchanged.
- R10: timeout_req rises on the 40th bit_tick (TO_TICKS = 4 characters of 10 bits) that counts with no push or pop, while level is nonzero and below the threshold. A pop clears it on the next cycle.
- R11: A control write that changes the enable bit empties the receive store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_byte | input | 8 | Control byte: bit 0 enable, bit 1 clear receive, bit 2 clear transmit, bits 7:6 threshold select |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| rd_en | input | 1 | Host read of the receive buffer |
| lsr_rd | input | 1 | Host read of line status; clears overrun |
| rd_data | output | 8 | Last byte popped |
| level | output | 5 | Number of bytes stored |
| data_ready | output | 1 | At least one byte stored |
| avail_req | output | 1 | Level at or above threshold |
| timeout_req | output | 1 | Character timeout request |
| overrun | output | 1 | A byte was dropped on a full store |
| fifo_mode | output | 2 | 11 with queuing on, 00 with queuing off |
| tx_flush | output | 1 | One-cycle pulse asking the transmit queue to empty |

## Verification
A corrupted read or write pointer shows up at rd_data as a wrong or reordered byte on the very next pop. The scoreboard compares every pop against the arrival order. A wrong level count shows up in the same cycle on data_ready and avail_req, and it breaks the full-store drop at the 17th byte. A timer that is off by one tick moves the rise of timeout_req away from the 40th tick, which the bench checks on both sides. A control register that latches bits it should ignore shows up one cycle after the write, as a spurious tx_flush pulse or an emptied store.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       fifo_en;
        logic [1:0] trig;
        logic       tx_flush;
    } rxq_cfg_t;

    // Threshold selected by control bits 7:6
    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8'd1;
            2'b01:   return 8'd4;
            2'b10:   return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_byte,
    output logic       fifo_en,
    output logic [1:0] trig,
    output logic       tx_flush,
    output logic       rx_flush
);
    rxq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d          = cfg_q;
        cfg_d.tx_flush = 1'b0;
        rx_flush       = 1'b0;
        if (cfg_wr) begin
            cfg_d.fifo_en = cfg_byte[0];
            // a change of mode always empties the store
            if (cfg_byte[0] != cfg_q.fifo_en) rx_flush = 1'b1;
            if (cfg_byte[0]) begin
                cfg_d.trig     = cfg_byte[7:6];
                cfg_d.tx_flush = cfg_byte[2];
                if (cfg_byte[1]) rx_flush = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign fifo_en  = cfg_q.fifo_en;
    assign trig     = cfg_q.trig;
    assign tx_flush = cfg_q.tx_flush;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int TO_TICKS = 40,
    localparam int CW = $clog2(TO_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic armed,
    input  logic activity,
    output logic timeout
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (activity || !armed) begin
            tmr_d.cnt  = '0;
            tmr_d.flag = 1'b0;
        end else if (bit_tick && !tmr_q.flag) begin
            if (tmr_q.cnt == CW'(TO_TICKS - 1)) tmr_d.flag = 1'b1;
            else                                tmr_d.cnt  = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign timeout = tmr_q.flag;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int W             = 8,
    parameter int BITS_PER_CHAR = 10,
    parameter int TIMEOUT_CHARS = 4,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int LVL_W    = $clog2(DEPTH + 1),
    localparam int TO_TICKS = BITS_PER_CHAR * TIMEOUT_CHARS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_byte,
    input  logic             rx_valid,
    input  logic [W-1:0]     rx_byte,
    input  logic             bit_tick,
    input  logic             rd_en,
    input  logic             lsr_rd,
    output logic [W-1:0]     rd_data,
    output logic [LVL_W-1:0] level,
    output logic             data_ready,
    output logic             avail_req,
    output logic             timeout_req,
    output logic             overrun,
    output logic [1:0]       fifo_mode,
    output logic             tx_flush
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
        logic [W-1:0]     rd_data;
        logic             overrun;
    } q_state_t;

    q_state_t st_d, st_q;

    logic             fifo_en, rx_flush;
    logic [1:0]       trig;
    logic [W-1:0]     mem_rdata;
    logic [LVL_W-1:0] cap, thresh, lvl_after_pop;
    logic             pop, push;

    rxq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_byte (cfg_byte),
        .fifo_en  (fifo_en),
        .trig     (trig),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush)
    );

    rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (st_q.wr_ptr),
        .wdata (rx_byte),
        .raddr (st_q.rd_ptr),
        .rdata (mem_rdata)
    );

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap           = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);
        thresh        = fifo_en ? LVL_W'(trig_level(trig)) : LVL_W'(1);
        pop           = rd_en && (st_q.level != '0) && !rx_flush;
        lvl_after_pop = st_q.level - LVL_W'(pop);
        push          = rx_valid && !rx_flush && (lvl_after_pop < cap);

        st_d = st_q;
        if (rx_flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.level  = '0;
        end else begin
            if (pop) begin
                st_d.rd_data = mem_rdata;
                st_d.rd_ptr  = bump(st_q.rd_ptr);
            end
            if (push) st_d.wr_ptr = bump(st_q.wr_ptr);
            st_d.level = lvl_after_pop + LVL_W'(push);
        end

        if (lsr_rd) st_d.overrun = 1'b0;
        if (rx_valid && !rx_flush && !push) st_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_timer #(.TO_TICKS(TO_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .armed    ((st_q.level != '0) && (st_q.level < thresh)),
        .activity (pop || push || rx_flush),
        .timeout  (timeout_req)
    );

    assign rd_data    = st_q.rd_data;
    assign level      = st_q.level;
    assign data_ready = (st_q.level != '0);
    assign avail_req  = (st_q.level >= thresh);
    assign overrun    = st_q.overrun;
    assign fifo_mode  = {fifo_en, fifo_en};
endmodule

// File: rtl/rxq_top_chk.sv
module rxq_top_chk #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             rx_valid,
    input logic             rd_en,
    input logic [W-1:0]     rd_data,
    input logic [LVL_W-1:0] level,
    input logic             data_ready,
    input logic             timeout_req,
    input logic             overrun,
    input logic [1:0]       fifo_mode,
    input logic             tx_flush
);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH)) && rx_valid && !rd_en && !cfg_wr
        |=> overrun && (level == LVL_W'(DEPTH)));

    p_mode_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fifo_mode) != 1);

    p_single_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode == 2'b00) |-> (level <= LVL_W'(1)));

    p_tx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush && !cfg_wr |=> !tx_flush);

    p_last_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (level == LVL_W'(1)) && !rx_valid && !cfg_wr |=> !data_ready);

    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (level == '0) && !rx_valid && !cfg_wr
        |=> (level == '0) && $stable(rd_data));

    p_timeout_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && data_ready && !cfg_wr |=> !timeout_req);
endmodule

bind rxq_top rxq_top_chk #(.DEPTH(DEPTH), .W(W), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .rx_valid    (rx_valid),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .level       (level),
    .data_ready  (data_ready),
    .timeout_req (timeout_req),
    .overrun     (overrun),
    .fifo_mode   (fifo_mode),
    .tx_flush    (tx_flush)
);

// File: tb/rxq_top_test.sv
module rxq_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       bit_tick = 1'b0;
    logic       rd_en = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_ready, avail_req, timeout_req, overrun, tx_flush;
    logic [1:0] fifo_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic [7:0] chk_q[$];
    logic [7:0] lastv = 8'h00;
    bit         men = 0;
    logic       pend = 1'b0;

    always #2 clk = ~clk;

    rxq_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .bit_tick(bit_tick),
        .rd_en(rd_en), .lsr_rd(lsr_rd), .rd_data(rd_data), .level(level),
        .data_ready(data_ready), .avail_req(avail_req),
        .timeout_req(timeout_req), .overrun(overrun),
        .fifo_mode(fifo_mode), .tx_flush(tx_flush)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compares every popped byte against the scoreboard
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend && rst_n) begin
            logic [7:0] e;
            e = chk_q.pop_front();
            check("R7 rd_data order", rd_data, e);
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_byte = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (v[0] != men || (v[0] && v[1])) exp_q.delete();
        men = v[0];
    endtask

    task automatic push(input logic [7:0] b);
        int cap;
        cap = men ? 16 : 1;
        rx_valid = 1'b1; rx_byte = b;
        if (exp_q.size() < cap) exp_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop();
        logic [7:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : lastv;
        lastv = e;
        chk_q.push_back(e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 level", level, 0);
        check("R1 data_ready", data_ready, 0);
        check("R1 avail_req", avail_req, 0);
        check("R1 timeout_req", timeout_req, 0);
        check("R1 overrun", overrun, 0);
        check("R1 fifo_mode", fifo_mode, 0);
        check("R1 tx_flush", tx_flush, 0);

        // R3 single-byte mode
        push(8'hA1);
        check("R3 level one", level, 1);
        check("R6 data_ready", data_ready, 1);
        check("R3 threshold 1", avail_req, 1);
        push(8'hA2);
        check("R8 drop keeps level", level, 1);
        check("R8 overrun set", overrun, 1);
        @(negedge clk);
        check("R8 overrun holds", overrun, 1);
        lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
        check("R8 overrun cleared", overrun, 0);
        pop();
        check("R6 data_ready low", data_ready, 0);
        push(8'hB1);
        write_cfg(8'hC6);
        check("R3 no clear when off", level, 1);
        check("R3 no tx pulse when off", tx_flush, 0);
        check("R2 mode off", fifo_mode, 0);
        pop();

        // R2 enable
        write_cfg(8'h01);
        check("R2 mode on", fifo_mode, 3);
        push(8'h11);
        check("R5 thresh 1", avail_req, 1);
        pop();

        // R5 thresh 4
        write_cfg(8'h41);
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i));
        check("R5 thresh 4 below", avail_req, 0);
        push(8'h23);
        check("R5 thresh 4 at", avail_req, 1);
        pop();
        check("R5 thresh 4 after read", avail_req, 0);
        repeat (3) pop();

        // R5 thresh 8, R4 receive clear
        write_cfg(8'h81);
        for (int i = 0; i < 7; i++) push(8'h30 + 8'(i));
        check("R5 thresh 8 below", avail_req, 0);
        push(8'h37);
        check("R5 thresh 8 at", avail_req, 1);
        write_cfg(8'h83);
        check("R4 rx cleared", level, 0);
        check("R4 no tx pulse", tx_flush, 0);
        push(8'h40); push(8'h41);
        check("R4 clear bit self-resets", level, 2);
        pop(); pop();

        // R4 transmit clear pulse, R5 thresh 14, R8 full
        write_cfg(8'hC5);
        check("R4 tx pulse high", tx_flush, 1);
        @(negedge clk);
        check("R4 tx pulse ends", tx_flush, 0);
        for (int i = 0; i < 13; i++) push(8'h50 + 8'(i));
        check("R5 thresh 14 below", avail_req, 0);
        push(8'h5D);
        check("R5 thresh 14 at", avail_req, 1);
        push(8'h5E); push(8'h5F);
        check("R8 full level", level, 16);
        check("R8 no overrun yet", overrun, 0);
        push(8'h99);
        check("R8 full drop level", level, 16);
        check("R8 full overrun", overrun, 1);
        for (int i = 0; i < 16; i++) pop();
        check("R6 empty", data_ready, 0);
        pop();
        check("R9 empty read level", level, 0);
        check("R9 empty read value", rd_data, 8'h5F);

        // R10 timeout
        write_cfg(8'h41);
        push(8'h66);
        ticks(39);
        check("R10 no timeout at 39", timeout_req, 0);
        ticks(1);
        check("R10 timeout at 40", timeout_req, 1);
        pop();
        check("R10 cleared by read", timeout_req, 0);
        ticks(50);
        check("R10 no timeout when empty", timeout_req, 0);

        // R11 mode change flush
        push(8'h70); push(8'h71);
        write_cfg(8'h00);
        check("R11 flush on mode change", level, 0);
        check("R2 mode off again", fifo_mode, 0);
        pop();
        check("R9 value kept", rd_data, 8'h66);
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule